// File: doc/BRIEF.md
# Prioritized Three-Line Interrupt Controller

This block watches three external interrupt request lines and decides, once per clock, whether the CPU core should enter an interrupt and through which vector. It holds one 8-bit control register. The register combines an enable bit and a latched flag for each line, plus two general bits that are simply stored. A global interrupt-enable input, taken from the CPU status register, gates every acceptance.

When a request is accepted, the block raises a one-cycle take strobe. In the same cycle it presents the 16-bit vector address, the number of cycles the entry sequence costs, and a wake pulse when the core was idle. Software reads the control register with the live levels of lines 1 and 3 merged in, and clears flags by writing ones. A rising edge on line 3 also captures the low byte of a timer count. The stack push and the vector fetch belong to the core.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset the control register reads 0x00 with all lines low, the take strobe and wake pulse are low, and the capture latch holds 0x00.
- R2: The control register bit layout is: line 1 enable at bit 0 and flag at bit 1, line 2 enable at bit 2 and flag at bit 3, line 3 enable at bit 4 and flag at bit 5. A low-to-high transition on a line sets that line's flag. The flag stays set after the line drops.
- R3: A register write treats the flag bits (mask 0x2A) as write-one-to-clear: a 1 clears the flag and a 0 leaves it unchanged. Every other bit takes the written value. A rising edge in the same cycle as a clearing write leaves the flag set.
- R4: A read returns the register with bit 1 forced high while line 1 is high and bit 5 forced high while line 3 is high.
- R5: No interrupt is taken while the global enable input is low, or while the line's enable bit is clear.
- R6: Priority is fixed: line 1 first, then line 2, then line 3. The vectors are 0xFFFC, 0xFFFA and 0xFFF8 for lines 1, 2 and 3.
- R7: Lines 1 and 3 request service when the line is high or its flag is set. Line 2 requests service only while its line is high.
- R8: Accepting line 1 or line 3 clears that line's flag in the same cycle. Accepting line 2 leaves its flag unchanged.
- R9: Take is a single-cycle pulse. It appears in the cycle after the inputs that caused it, and no request is accepted in the cycle that follows a take.
- R10: With take, the entry cost output shows 19, or 17 when the idle input was high. In the idle case a wake pulse accompanies take.
- R11: On a rising edge of line 3, the capture latch loads the timer count present at that edge. The latch holds its value while the line stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| irq_in | input | 3 | Request lines, bit 0 is line 1 |
| gie | input | 1 | Global interrupt enable from the CPU status register |
| idle | input | 1 | Core is in the idle state |
| timer_cnt | input | TW | Timer count sampled on a line 3 rising edge |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control register write data |
| ctl_rdata | output | 8 | Control register read data, live levels merged |
| take | output | 1 | Interrupt accepted, one-cycle pulse |
| vector | output | AW | Vector address valid with take |
| entry_cycles | output | CW | Entry cost in cycles, valid with take |
| wake | output | 1 | Take while idle, clears the core's idle state |
| capture | output | TW | Timer capture latch |

## Verification
The assertions check, on every cycle, the relations between the inputs and the registered outputs. The take strobe never lasts two cycles and never appears without the global enable. A pending and enabled line 1 always wins with its vector, and line 2 wins over line 3 when line 1 is quiet. The entry cost follows the idle input, and each line 3 edge loads the timer count. The bench scenarios cover what a property cannot easily state: flags that persist after the line drops, write-one-to-clear losing to a simultaneous edge, acceptance clearing only the sticky flags, the read-side merge of live levels, disabled lines staying silent, and the reset state.

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl #(
  parameter int AW       = 16,
  parameter int TW       = 8,
  parameter int CW       = 5,
  parameter logic [AW-1:0] VEC_L1 = 16'hFFFC,
  parameter logic [AW-1:0] VEC_L2 = 16'hFFFA,
  parameter logic [AW-1:0] VEC_L3 = 16'hFFF8,
  parameter int CYC_RUN  = 19,
  parameter int CYC_WAKE = 17
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [2:0]    irq_in,
  input  logic          gie,
  input  logic          idle,
  input  logic [TW-1:0] timer_cnt,
  input  logic          ctl_we,
  input  logic [7:0]    ctl_wdata,
  output logic [7:0]    ctl_rdata,
  output logic          take,
  output logic [AW-1:0] vector,
  output logic [CW-1:0] entry_cycles,
  output logic          wake,
  output logic [TW-1:0] capture
);
  localparam logic [7:0] FLAG_M = 8'h2A;

  logic [7:0] ctl_q;
  logic [2:0] lvl_q;
  logic [2:0] rise;
  logic       fire1, fire2, fire3, arm;
  logic       acc1, acc2, acc3;
  logic [7:0] set_m, ack_m, base, ctl_d;

  assign rise  = irq_in & ~lvl_q;
  assign set_m = {2'b00, rise[2], 1'b0, rise[1], 1'b0, rise[0], 1'b0};

  assign fire1 = ctl_q[0] & (irq_in[0] | ctl_q[1]);
  assign fire2 = ctl_q[2] & irq_in[1];
  assign fire3 = ctl_q[4] & (irq_in[2] | ctl_q[5]);
  assign arm   = gie & ~take;

  assign acc1 = arm & fire1;
  assign acc2 = arm & ~fire1 & fire2;
  assign acc3 = arm & ~fire1 & ~fire2 & fire3;
  assign ack_m = {2'b00, acc3, 3'b000, acc1, 1'b0};

  assign base  = ctl_we ? ((ctl_wdata & ~FLAG_M) | (ctl_q & FLAG_M & ~ctl_wdata)) : ctl_q;
  assign ctl_d = (base | set_m) & ~ack_m;

  assign ctl_rdata = ctl_q | {2'b00, irq_in[2], 3'b000, irq_in[0], 1'b0};

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q        <= '0;
      lvl_q        <= '0;
      take         <= 1'b0;
      vector       <= '0;
      entry_cycles <= '0;
      wake         <= 1'b0;
      capture      <= '0;
    end else begin
      ctl_q <= ctl_d;
      lvl_q <= irq_in;
      take  <= acc1 | acc2 | acc3;
      wake  <= (acc1 | acc2 | acc3) & idle;
      if (acc1)      vector <= VEC_L1;
      else if (acc2) vector <= VEC_L2;
      else if (acc3) vector <= VEC_L3;
      if (acc1 | acc2 | acc3)
        entry_cycles <= idle ? CW'(CYC_WAKE) : CW'(CYC_RUN);
      else
        entry_cycles <= '0;
      if (rise[2]) capture <= timer_cnt;
    end
  end
endmodule

module prio_irq_ctrl_chk #(
  parameter int AW = 16,
  parameter int TW = 8,
  parameter int CW = 5,
  parameter logic [AW-1:0] VEC_L1 = 16'hFFFC,
  parameter logic [AW-1:0] VEC_L2 = 16'hFFFA,
  parameter int CYC_RUN  = 19,
  parameter int CYC_WAKE = 17
) (
  input logic          clk,
  input logic          rst,
  input logic [2:0]    irq_in,
  input logic          gie,
  input logic          idle,
  input logic [TW-1:0] timer_cnt,
  input logic [7:0]    ctl_rdata,
  input logic          take,
  input logic [AW-1:0] vector,
  input logic [CW-1:0] entry_cycles,
  input logic [TW-1:0] capture
);
  // R9
  single_take_chk: assert property (@(posedge clk) disable iff (rst) take |=> !take);

  // R5
  gie_gate_chk: assert property (@(posedge clk) disable iff (rst) take |-> $past(gie));

  // R6
  line1_first_chk: assert property (@(posedge clk) disable iff (rst)
    $past(gie && !take && ctl_rdata[0] && ctl_rdata[1]) |-> (take && vector == VEC_L1));

  // R7
  line2_level_chk: assert property (@(posedge clk) disable iff (rst)
    $past(gie && !take && ctl_rdata[2] && irq_in[1] && !(ctl_rdata[0] && ctl_rdata[1]))
      |-> (take && vector == VEC_L2));

  // R10
  entry_cost_chk: assert property (@(posedge clk) disable iff (rst)
    take |-> (entry_cycles == ($past(idle) ? CW'(CYC_WAKE) : CW'(CYC_RUN))));

  // R11
  capture_load_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past($rose(irq_in[2]))) |-> (capture == $past(timer_cnt)));
endmodule

bind prio_irq_ctrl prio_irq_ctrl_chk #(
  .AW(AW), .TW(TW), .CW(CW), .VEC_L1(VEC_L1), .VEC_L2(VEC_L2),
  .CYC_RUN(CYC_RUN), .CYC_WAKE(CYC_WAKE)
) u_chk (
  .clk(clk), .rst(rst), .irq_in(irq_in), .gie(gie), .idle(idle),
  .timer_cnt(timer_cnt), .ctl_rdata(ctl_rdata), .take(take), .vector(vector),
  .entry_cycles(entry_cycles), .capture(capture)
);

// File: tb/tb_prio_irq_ctrl.sv
module tb_prio_irq_ctrl;
  logic        clk = 1'b0;
  logic        rst;
  logic [2:0]  irq_in;
  logic        gie, idle, ctl_we;
  logic [7:0]  timer_cnt, ctl_wdata, ctl_rdata, capture;
  logic        take, wake;
  logic [15:0] vector;
  logic [4:0]  entry_cycles;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #10 clk = ~clk;

  prio_irq_ctrl dut (
    .clk(clk), .rst(rst), .irq_in(irq_in), .gie(gie), .idle(idle),
    .timer_cnt(timer_cnt), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .ctl_rdata(ctl_rdata), .take(take), .vector(vector),
    .entry_cycles(entry_cycles), .wake(wake), .capture(capture)
  );

  function automatic logic [38:0] mk(logic [2:0] irq, logic wr, logic [7:0] wd,
                                     logic g, logic id, logic et,
                                     logic [15:0] ev, logic [7:0] er);
    return {irq, wr, wd, g, id, et, ev, er};
  endfunction

  localparam int NV = 27;
  localparam logic [38:0] TBL [NV] = '{
    mk(3'b000, 1, 8'h15, 0, 0, 0, 16'h0000, 8'h15), // R3 enables stored
    mk(3'b001, 0, 8'h00, 0, 0, 0, 16'h0000, 8'h17), // R2 edge sets flag, R5 gie low
    mk(3'b000, 0, 8'h00, 0, 0, 0, 16'h0000, 8'h17), // R2 sticky
    mk(3'b000, 0, 8'h00, 1, 0, 1, 16'hFFFC, 8'h15), // R7 flag fires, R8 cleared
    mk(3'b000, 0, 8'h00, 1, 0, 0, 16'h0000, 8'h15),
    mk(3'b010, 0, 8'h00, 0, 0, 0, 16'h0000, 8'h1D), // R2 line 2 flag
    mk(3'b000, 0, 8'h00, 1, 0, 0, 16'h0000, 8'h1D), // R7 line 2 flag alone no take
    mk(3'b110, 0, 8'h00, 0, 0, 0, 16'h0000, 8'h3D),
    mk(3'b110, 0, 8'h00, 1, 0, 1, 16'hFFFA, 8'h3D), // R6 line 2 over 3, R8 flag kept
    mk(3'b110, 0, 8'h00, 1, 0, 0, 16'h0000, 8'h3D), // R9 suppressed after take
    mk(3'b010, 0, 8'h00, 1, 0, 1, 16'hFFFA, 8'h3D), // R7 level fires again
    mk(3'b000, 1, 8'h1D, 0, 0, 0, 16'h0000, 8'h35), // R3 clear bit 3 only
    mk(3'b000, 0, 8'h00, 1, 1, 1, 16'hFFF8, 8'h15), // R10 idle entry, R8
    mk(3'b000, 0, 8'h00, 1, 0, 0, 16'h0000, 8'h15),
    mk(3'b000, 1, 8'hC0, 0, 0, 0, 16'h0000, 8'hC0), // R3 plain bits stored
    mk(3'b101, 0, 8'h00, 1, 0, 0, 16'h0000, 8'hE2), // R5 disabled lines
    mk(3'b000, 0, 8'h00, 1, 0, 0, 16'h0000, 8'hE2), // R5
    mk(3'b000, 1, 8'hD5, 0, 0, 0, 16'h0000, 8'hF7), // R3 zero keeps flags
    mk(3'b000, 0, 8'h00, 1, 0, 1, 16'hFFFC, 8'hF5), // R6 line 1 over 3
    mk(3'b000, 0, 8'h00, 1, 0, 0, 16'h0000, 8'hF5), // R9
    mk(3'b000, 0, 8'h00, 1, 0, 1, 16'hFFF8, 8'hD5), // R8 line 3 flag cleared
    mk(3'b001, 1, 8'h02, 0, 0, 0, 16'h0000, 8'h02), // R3 edge beats clear
    mk(3'b000, 0, 8'h00, 0, 0, 0, 16'h0000, 8'h02),
    mk(3'b000, 1, 8'h2A, 0, 0, 0, 16'h0000, 8'h00), // R3 clear all
    mk(3'b101, 0, 8'h00, 0, 0, 0, 16'h0000, 8'h22),
    mk(3'b101, 1, 8'h22, 0, 0, 0, 16'h0000, 8'h22), // R4 live levels merged
    mk(3'b000, 0, 8'h00, 0, 0, 0, 16'h0000, 8'h00)  // R4
  };

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    rst = 1; irq_in = 0; gie = 0; idle = 0; ctl_we = 0; ctl_wdata = 0; timer_cnt = 8'hA5;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    chk("R1 ctl_rdata", 32'(ctl_rdata), 32'h00);
    chk("R1 take", 32'(take), 0);
    chk("R1 capture", 32'(capture), 0);

    for (int i = 0; i < NV; i++) begin
      logic [38:0] v;
      v = TBL[i];
      irq_in = v[38:36]; ctl_we = v[35]; ctl_wdata = v[34:27];
      gie = v[26]; idle = v[25];
      @(posedge clk);
      #5;
      chk($sformatf("R9 take row %0d", i), 32'(take), 32'(v[24]));
      chk($sformatf("R2 ctl_rdata row %0d", i), 32'(ctl_rdata), 32'(v[7:0]));
      if (v[24]) begin
        chk($sformatf("R6 vector row %0d", i), 32'(vector), 32'(v[23:8]));
        chk($sformatf("R10 cycles row %0d", i), 32'(entry_cycles), v[25] ? 32'd17 : 32'd19);
        chk($sformatf("R10 wake row %0d", i), 32'(wake), 32'(v[25]));
      end
      @(negedge clk);
    end

    ctl_we = 0; gie = 0; idle = 0; irq_in = 3'b000; timer_cnt = 8'h5A;
    @(negedge clk);
    irq_in = 3'b100;
    @(posedge clk); #5;
    chk("R11 capture on edge", 32'(capture), 32'h5A);
    @(negedge clk);
    timer_cnt = 8'h33;
    @(posedge clk); #5;
    chk("R11 capture held", 32'(capture), 32'h5A);

    @(negedge clk);
    rst = 1; irq_in = 3'b000;
    @(posedge clk); #5;
    chk("R1 reset ctl", 32'(ctl_rdata), 32'h00);
    chk("R1 reset capture", 32'(capture), 32'h00);
    chk("R1 reset take", 32'(take), 0);
    @(negedge clk);
    rst = 0;

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule